// File: doc/BRIEF.md
# Integer Compare, Byte-Match and Leading-Zero Unit

This block is a 32-bit integer helper for a small RISC execution stage. An operation select picks one of five functions on two operands and a carry input: signed compare, unsigned compare, byte-position match, leading-zero count, and add with carry. The result has the full word width and comes with a carry output.

The compare operations do not return a flag. They return the difference `b - a` with its top bit adjusted so that the top bit alone gives the ordering. Software can then branch on the sign of the result. The byte match reports the first byte position, counted from the most significant byte, at which the two operands agree.

A parameter chooses between a registered output stage (the default) and a purely combinational path. Register file access, flag storage and instruction decode live outside this block.

Top module: `cmp_match_unit`

## Requirements
- R1: With opSel = 0 (signed compare), bits 30:0 of the result equal bits 30:0 of `b - a`. Bit 31 is 1 exactly when `b < a` as two's-complement values. Equivalently, bit 31 is taken from `b` when the operand sign bits differ.
- R2: With opSel = 1 (unsigned compare), bits 30:0 of the result equal bits 30:0 of `b - a`. Bit 31 is 1 exactly when `b < a` as unsigned values. Equivalently, bit 31 is taken from `a` when the operand sign bits differ.
- R3: With opSel = 2 (byte match), the bytes are examined from bits 31:24 down to bits 7:0. The result is 1, 2, 3 or 4 for the first of these positions where `a` and `b` hold equal bytes, and 0 when no byte position is equal.
- R4: With opSel = 3, the result is the number of zero bits of `a` above its highest set bit. An all-zero `a` gives 32.
- R5: With opSel = 4, the result is the low 32 bits of `a + b + carryIn`. carryOut is 1 when that sum exceeds 2^32 - 1, which includes the case where `b` is all ones and carryIn is 1.
- R6: opSel codes 5, 6 and 7 give a result of 0 and a carryOut of 0.
- R7: carryOut is 0 for every operation other than add with carry.
- R8: With the default registered output, resultOut and carryOut are 0 while rstN is low. They show the outcome for the inputs that were present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rstN | input | 1 | Asynchronous active-low reset |
| opSel | input | 3 | Operation code (0..4 used) |
| opA | input | 32 | Operand a |
| opB | input | 32 | Operand b |
| carryIn | input | 1 | Carry into the add |
| resultOut | output | 32 | Operation result |
| carryOut | output | 1 | Carry out of the add |

## Verification
The assertions sample opSel, the operands and carryIn at the rising edge. They assume these inputs are settled there and hold no unknown bits, so the decode produces at most one strobe. The bench changes inputs only on the falling edge, and it drives every input from reset onward with defined values. The sweeps pair the boundary words 0, all-ones, 0x80000000 and 0x7FFFFFFF with each other and with random words. Operand b is built from a by copying chosen bytes, so that every subset of equal byte positions occurs in the byte-match sweep.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_CMP_S = 3'd0;
  localparam logic [OP_W-1:0] OP_CMP_U = 3'd1;
  localparam logic [OP_W-1:0] OP_MATCH = 3'd2;
  localparam logic [OP_W-1:0] OP_LZC   = 3'd3;
  localparam logic [OP_W-1:0] OP_ADDC  = 3'd4;

  // strobes from decode to datapath
  typedef struct packed {
    logic selCmp;
    logic cmpUns;
    logic selMatch;
    logic selLzc;
    logic selAdd;
  } strobe_t;
endpackage

// File: rtl/cmu_ctrl.sv
module cmu_ctrl
  import cmu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opSel,
  output strobe_t         strb
);
  always_comb begin
    strb = '0;
    case (opSel)
      OP_CMP_S: strb.selCmp = 1'b1;
      OP_CMP_U: begin
        strb.selCmp = 1'b1;
        strb.cmpUns = 1'b1;
      end
      OP_MATCH: strb.selMatch = 1'b1;
      OP_LZC:   strb.selLzc = 1'b1;
      OP_ADDC:  strb.selAdd = 1'b1;
      default:  strb = '0;
    endcase
  end

  AST_ONE_FUNCTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selCmp, strb.selMatch, strb.selLzc, strb.selAdd})) else $error("strobes overlap"); // R6
  AST_SPARE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (opSel > OP_ADDC) |-> (strb == '0)) else $error("spare code raised a strobe"); // R6
endmodule

// File: rtl/cmu_dpath.sv
module cmu_dpath
  import cmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] resNext,
  output logic              carryNext
);
  localparam int LANES = DATA_W / 8;
  localparam int MSB   = DATA_W - 1;
  localparam int POS_W = $clog2(LANES + 1);
  localparam int CNT_W = $clog2(DATA_W + 1);

  // compare: difference with ordering folded into the top bit
  logic [DATA_W-1:0] diff;
  logic              signMix;
  logic [DATA_W-1:0] cmpRes;

  assign diff    = opB + ~opA + {{(DATA_W-1){1'b0}}, 1'b1};
  assign signMix = opA[MSB] ^ opB[MSB];
  assign cmpRes  = {signMix ? (strb.cmpUns ? opA[MSB] : opB[MSB]) : diff[MSB], diff[MSB-1:0]};

  // byte lanes
  logic [LANES-1:0] laneEq;
  logic [POS_W-1:0] matchPos;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneEq[g] = (opA[g*8 +: 8] == opB[g*8 +: 8]);
  end

  always_comb begin
    matchPos = '0;
    for (int i = 0; i < LANES; i++) begin
      if (laneEq[i]) matchPos = POS_W'(LANES - i);
    end
  end

  // leading zeros of operand a
  logic [CNT_W-1:0] lzCnt;

  always_comb begin
    lzCnt = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (opA[i]) lzCnt = CNT_W'(MSB - i);
    end
  end

  // add with carry
  logic [DATA_W:0] sum;
  assign sum = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};

  always_comb begin
    resNext   = '0;
    carryNext = 1'b0;
    if (strb.selCmp)        resNext = cmpRes;
    else if (strb.selMatch) resNext = {{(DATA_W-POS_W){1'b0}}, matchPos};
    else if (strb.selLzc)   resNext = {{(DATA_W-CNT_W){1'b0}}, lzCnt};
    else if (strb.selAdd) begin
      resNext   = sum[DATA_W-1:0];
      carryNext = sum[DATA_W];
    end
  end

  AST_SIGNED_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selCmp && !strb.cmpUns) |-> (resNext[MSB] == ($signed(opB) < $signed(opA)))) else $error("signed order"); // R1
  AST_UNSIGNED_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selCmp && strb.cmpUns) |-> (resNext[MSB] == (opB < opA))) else $error("unsigned order"); // R2
  AST_MATCH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strb.selMatch |-> (resNext <= DATA_W'(LANES))) else $error("match out of range"); // R3
  AST_MATCH_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selMatch && (opA[MSB -: 8] == opB[MSB -: 8])) |-> (resNext == DATA_W'(1))) else $error("top lane missed"); // R3
  AST_LZC_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selLzc && opA[MSB]) |-> (resNext == '0)) else $error("lzc top bit"); // R4
  AST_LZC_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selLzc && (opA == '0)) |-> (resNext == DATA_W'(DATA_W))) else $error("lzc of zero"); // R4
  AST_CARRY_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selAdd && (&opB) && carryIn) |-> carryNext) else $error("carry lost"); // R5
  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !strb.selAdd |-> !carryNext) else $error("stray carry"); // R7
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
  import cmu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              carryOut
);
  strobe_t           strb;
  logic [DATA_W-1:0] resNext;
  logic              carryNext;

  cmu_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .opSel (opSel),
    .strb  (strb)
  );

  cmu_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .resNext   (resNext),
    .carryNext (carryNext)
  );

  if (OUT_REG) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resultOut <= '0;
        carryOut  <= 1'b0;
      end else begin
        resultOut <= resNext;
        carryOut  <= carryNext;
      end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
      !rstN |-> (resultOut == '0 && !carryOut)) else $error("outputs not cleared"); // R8
  end else begin : gComb
    assign resultOut = resNext;
    assign carryOut  = carryNext;
  end
endmodule

// File: tb/cmp_match_unit_bench.sv
module cmp_match_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opSel = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [31:0] resultOut;
  logic        carryOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  cmp_match_unit u_cmp_match_unit (
    .clk(clk), .rstN(rstN), .opSel(opSel), .opA(opA), .opB(opB),
    .carryIn(carryIn), .resultOut(resultOut), .carryOut(carryOut)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, logic [32:0] act, logic [32:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (op=%0d a=%h b=%h c=%b)",
               tag, act, exp, opSel, opA, opB, carryIn);
    end
  endtask

  function automatic logic [32:0] model(logic [2:0] op, logic [31:0] a, logic [31:0] b, logic c);
    logic [32:0] s;
    logic [31:0] d;
    int n;
    d = b - a;
    case (op)
      3'd0: return {1'b0, ($signed(b) < $signed(a)), d[30:0]};
      3'd1: return {1'b0, (b < a), d[30:0]};
      3'd2: begin
        for (int k = 0; k < 4; k++)
          if (a[31-8*k -: 8] == b[31-8*k -: 8]) return 33'(k + 1);
        return '0;
      end
      3'd3: begin
        n = 0;
        while (n < 32 && a[31-n] == 1'b0) n++;
        return 33'(n);
      end
      3'd4: begin
        s = 33'(a) + 33'(b) + 33'(c);
        return {s[32], s[31:0]};
      end
      default: return '0;
    endcase
  endfunction

  function automatic string tagOf(logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic runOne(logic [2:0] op, logic [31:0] a, logic [31:0] b, logic c);
    logic [32:0] exp;
    opSel = op; opA = a; opB = b; carryIn = c;
    exp = model(op, a, b, c);
    @(posedge clk);
    @(negedge clk);
    check(tagOf(op), {carryOut, resultOut}, exp);
    if (op != 3'd4) check("R7", {32'd0, carryOut}, 33'd0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=done");
    finish();
  end

  initial begin
    logic [31:0] corner [8];
    logic [31:0] a, b;
    corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF;
    corner[2] = 32'h8000_0000; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h0000_0001; corner[5] = 32'h1234_5678;
    corner[6] = 32'h0012_0078; corner[7] = 32'hFF00_FF00;

    // R8: reset holds outputs clear
    opSel = 3'd4; opA = '1; opB = '1; carryIn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", {carryOut, resultOut}, 33'd0);
    rstN = 1'b1;

    // R8: one-cycle latency
    opSel = 3'd3; opA = 32'd0; opB = 32'd0; carryIn = 1'b0;
    #1 check("R8", {carryOut, resultOut}, 33'd0);
    @(posedge clk);
    @(negedge clk);
    check("R8", {carryOut, resultOut}, 33'd32);

    // corner sweep over all codes
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int c = 0; c < 2; c++)
            runOne(3'(op), corner[i], corner[j], 1'(c));

    // random operands, all codes
    for (int n = 0; n < 3000; n++)
      runOne(3'(n % 8), $urandom, $urandom, 1'($urandom));

    // R3: every subset of equal byte lanes
    for (int m = 0; m < 16; m++)
      for (int n = 0; n < 100; n++) begin
        a = $urandom;
        b = a;
        for (int k = 0; k < 4; k++)
          if (!m[k]) b[8*k +: 8] = a[8*k +: 8] ^ 8'(1 + ($urandom % 255));
        runOne(3'd2, a, b, 1'b0);
      end

    // R4: single set bit at each position, with lower noise
    for (int p = 0; p < 32; p++) begin
      a = (32'd1 << p) | (($urandom) & ((32'd1 << p) - 1));
      runOne(3'd3, a, 32'd0, 1'b0);
    end

    // R5: carry boundary cases
    runOne(3'd4, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1);
    runOne(3'd4, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0);
    runOne(3'd4, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0);
    runOne(3'd4, 32'h8000_0000, 32'h8000_0000, 1'b0);

    finish();
  end
endmodule